// File: doc/BRIEF.md
# Segmented External Bus Cycle Sequencer

This block runs one external bus cycle at a time on behalf of a processor core. The core offers a single-clock request with a segment number, an address, a write flag and write data. The block then holds the matching segment enable, the address and, for writes, the data and write strobe for a number of clocks set per segment. In the last clock of the cycle it pulses `done` and captures the read data.

Two registers shape the cycles. The wait register gives each of the four segments its own wait-state count. The configuration register has several jobs. It can hold off the leading edge of any segment enable, or of the device-select strobe, by half a clock so that two devices never drive the data bus at once. It sets the polarity of device select. It decides whether the external ROM segment may be written, and whether address bit 15 is cleared for ROM accesses. Two strap pins pick the reset value of the wait register.

Top module: `segbus_top`

## Requirements
- R1: The wait register holds one 4-bit field per segment at bits 4s+3..4s for segment s (0 low RAM, 1 I/O, 2 high RAM, 3 external ROM). A request taken while idle makes `busy` high for exactly 1 + w clocks, starting the clock after the edge that samples `reqValid`, where w is the field of the requested segment.
- R2: `done` is high only in the final clock of an access. For a read, `rdData` takes the value of `busDataIn` at the edge that ends that clock and holds it until the next read.
- R3: While `rstN` is low the wait register is cleared to all zeros if `strapExm` and `strapQuick` are both 1, and set to all ones in every other case. The configuration register resets to zero.
- R4: During an access exactly one enable, `segEn[s]` for the requested segment s, is high. When idle all enables are low.
- R5: Configuration bit s (s = 0..3) delays the leading edge of `segEn[s]` by half a clock: the enable is low in the first half of the first clock and high from then until the cycle ends. With the bit clear the enable is high for the whole cycle.
- R6: `devSel` is asserted during I/O segment accesses only. The asserted level equals configuration bit 6 (1 active-high, 0 active-low) and the idle level is its inverse. Configuration bit 4 delays its leading edge by half a clock, as in R5.
- R7: `wrStrobe` is high on a write, with the same timing as the segment enable. For the external ROM segment it is high only if configuration bit 11 is 1; otherwise it stays low for the whole access.
- R8: `busAddr` carries the request address during the access. Bit 15 is forced to 0 only when the segment is external ROM and configuration bits 14 and 11 are both 1.
- R9: A register write (`cfgWrEn`, with `cfgSel` 0 for the wait register and 1 for configuration) and a new request are both ignored while `busy` is high.
- R10: During a write `busDataOut` carries the request data while `wrStrobe` is high, and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strapExm | input | 1 | Strap: external memory boot |
| strapQuick | input | 1 | Strap: zero wait states at reset when high with strapExm |
| cfgWrEn | input | 1 | Register write strobe |
| cfgSel | input | 1 | Register select: 0 wait, 1 configuration |
| cfgWrData | input | DATA_W | Register write data |
| reqValid | input | 1 | Access request (one clock) |
| reqSeg | input | 2 | Requested segment |
| reqAddr | input | ADDR_W | Request address |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqWData | input | DATA_W | Write data |
| busDataIn | input | DATA_W | Data returned by the external device |
| busy | output | 1 | Access in progress |
| done | output | 1 | Final clock of the access |
| rdData | output | DATA_W | Captured read data |
| segEn | output | 4 | Active-high segment enables |
| devSel | output | 1 | Device-select strobe, programmable polarity |
| wrStrobe | output | 1 | Active-high write strobe |
| busAddr | output | ADDR_W | External address |
| busDataOut | output | DATA_W | External write data |

## Verification
Every segment is swept over all sixteen wait counts. The other three fields are loaded with the complement count, so a wrong field mapping shows up as a wrong cycle length. Each point runs as a plain read, a delayed read, a write with ROM writes blocked and a write with ROM writes allowed plus address clearing. Sampling both clock halves separates delayed from undelayed enables and device select. Polarity alternates with the wait count, and all four strap combinations are reset and measured. One access has a register write and a request injected in its middle; the following accesses tell apart a register that obeyed the ignore rule from one that took the write or launched an extra cycle.

// File: rtl/segbus_pkg.sv
package segbus_pkg;
  localparam int SEG_N = 4;
  localparam int SEG_W = 2;
  localparam int SEG_LOWRAM = 0;
  localparam int SEG_IO = 1;
  localparam int SEG_HIRAM = 2;
  localparam int SEG_ROM = 3;
  localparam int CFG_SEL_DELAY = 4;
  localparam int CFG_SEL_POL = 6;
  localparam int CFG_ROM_WRITE = 11;
  localparam int CFG_ROM_LOW = 14;

  typedef struct packed {
    logic launch;
    logic active;
    logic last;
    logic lateHalf;
  } busStrobe_t;
endpackage

// File: rtl/segbus_ctl.sv
module segbus_ctl
  import segbus_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [WAIT_W-1:0] waitSel,
  output busStrobe_t        stb
);
  logic              active;
  logic [WAIT_W-1:0] remain;
  logic              halfQ;
  logic              launch;
  logic              last;

  assign launch = reqValid && !active;
  assign last   = active && (remain == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      remain <= '0;
    end else if (launch) begin
      active <= 1'b1;
      remain <= waitSel;
    end else if (active) begin
      if (last) active <= 1'b0;
      else      remain <= remain - 1'b1;
    end
  end

  // copy of the busy state taken mid-clock; low during the first half of a new cycle
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) halfQ <= 1'b0;
    else       halfQ <= active;
  end

  always_comb begin
    stb.launch   = launch;
    stb.active   = active;
    stb.last     = last;
    stb.lateHalf = active && halfQ;
  end
endmodule

// File: rtl/segbus_dp.sv
module segbus_dp
  import segbus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapExm,
  input  logic              strapQuick,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic [SEG_W-1:0]  reqSeg,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWData,
  input  logic [DATA_W-1:0] busDataIn,
  input  busStrobe_t        stb,
  output logic [WAIT_W-1:0] waitSel,
  output logic [SEG_N-1:0]  segEn,
  output logic              devSel,
  output logic              wrStrobe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDataOut,
  output logic [DATA_W-1:0] rdData
);
  localparam int WREG_W = SEG_N * WAIT_W;

  logic [WREG_W-1:0] waitReg;
  logic [DATA_W-1:0] cfgReg;
  logic [SEG_W-1:0]  segQ;
  logic [ADDR_W-1:0] addrQ;
  logic              writeQ;
  logic [DATA_W-1:0] wdataQ;
  logic [SEG_N-1:0]  segOn;
  logic              writeAllowed;
  logic              selOn;
  logic              romLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitReg <= (strapExm && strapQuick) ? '0 : '1;
      cfgReg  <= '0;
    end else if (cfgWrEn && !stb.active) begin
      if (cfgSel) cfgReg  <= cfgWrData;
      else        waitReg <= cfgWrData[WREG_W-1:0];
    end
  end

  assign waitSel = waitReg[reqSeg*WAIT_W +: WAIT_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segQ   <= '0;
      addrQ  <= '0;
      writeQ <= 1'b0;
      wdataQ <= '0;
    end else if (stb.launch) begin
      segQ   <= reqSeg;
      addrQ  <= reqAddr;
      writeQ <= reqWrite;
      wdataQ <= reqWData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    rdData <= '0;
    else if (stb.last && !writeQ) rdData <= busDataIn;
  end

  for (genvar s = 0; s < SEG_N; s++) begin : g_seg
    assign segOn[s] = stb.active && (segQ == SEG_W'(s)) &&
                      (!cfgReg[s] || stb.lateHalf);
  end
  assign segEn = segOn;

  assign selOn  = stb.active && (segQ == SEG_W'(SEG_IO)) &&
                  (!cfgReg[CFG_SEL_DELAY] || stb.lateHalf);
  assign devSel = selOn ? cfgReg[CFG_SEL_POL] : !cfgReg[CFG_SEL_POL];

  assign writeAllowed = (segQ != SEG_W'(SEG_ROM)) || cfgReg[CFG_ROM_WRITE];
  assign wrStrobe     = writeQ && writeAllowed && (|segOn);
  assign busDataOut   = wrStrobe ? wdataQ : '0;

  assign romLow = (segQ == SEG_W'(SEG_ROM)) && cfgReg[CFG_ROM_LOW] && cfgReg[CFG_ROM_WRITE];
  always_comb begin
    busAddr = addrQ;
    if (romLow) busAddr[ADDR_W-1] = 1'b0;
  end
endmodule

// File: rtl/segbus_top.sv
module segbus_top
  import segbus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapExm,
  input  logic              strapQuick,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              reqValid,
  input  logic [1:0]        reqSeg,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWData,
  input  logic [DATA_W-1:0] busDataIn,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic [3:0]        segEn,
  output logic              devSel,
  output logic              wrStrobe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDataOut
);
  busStrobe_t        stb;
  logic [WAIT_W-1:0] waitSel;

  segbus_ctl #(.WAIT_W(WAIT_W)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .waitSel  (waitSel),
    .stb      (stb)
  );

  segbus_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strapExm   (strapExm),
    .strapQuick (strapQuick),
    .cfgWrEn    (cfgWrEn),
    .cfgSel     (cfgSel),
    .cfgWrData  (cfgWrData),
    .reqSeg     (reqSeg),
    .reqAddr    (reqAddr),
    .reqWrite   (reqWrite),
    .reqWData   (reqWData),
    .busDataIn  (busDataIn),
    .stb        (stb),
    .waitSel    (waitSel),
    .segEn      (segEn),
    .devSel     (devSel),
    .wrStrobe   (wrStrobe),
    .busAddr    (busAddr),
    .busDataOut (busDataOut),
    .rdData     (rdData)
  );

  assign busy = stb.active;
  assign done = stb.last;
endmodule

// File: rtl/segbus_chk.sv
module segbus_chk #(
  parameter int DATA_W = 16,
  parameter int WAIT_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              strapExm,
  input logic              strapQuick,
  input logic              cfgWrEn,
  input logic              cfgSel,
  input logic [DATA_W-1:0] cfgWrData,
  input logic              reqValid,
  input logic [1:0]        reqSeg,
  input logic              busy,
  input logic              done,
  input logic [3:0]        segEn,
  input logic              devSel,
  input logic              wrStrobe
);
  logic [4*WAIT_W-1:0] waitSh;
  logic [DATA_W-1:0]   cfgSh;
  logic [1:0]          segSh;
  logic [WAIT_W-1:0]   wSh;
  logic [WAIT_W:0]     cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitSh <= (strapExm && strapQuick) ? '0 : '1;
      cfgSh  <= '0;
      segSh  <= '0;
      wSh    <= '0;
      cnt    <= '0;
    end else begin
      if (cfgWrEn && !busy) begin
        if (cfgSel) cfgSh  <= cfgWrData;
        else        waitSh <= cfgWrData[4*WAIT_W-1:0];
      end
      if (reqValid && !busy) begin
        segSh <= reqSeg;
        wSh   <= waitSh[reqSeg*WAIT_W +: WAIT_W];
        cnt   <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_length_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cnt == {1'b0, wSh}));
  p_done_in_access_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
  p_done_ends_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  p_enable_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(segEn));
  p_enable_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (segEn == 4'b0000));
  p_enable_match_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> segEn[segSh]);
  p_sel_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (devSel == !cfgSh[6]));
  p_rom_guard_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && segSh == 2'd3 && !cfgSh[11]) |-> !wrStrobe);
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);
endmodule

bind segbus_top segbus_chk #(.DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .strapExm   (strapExm),
  .strapQuick (strapQuick),
  .cfgWrEn    (cfgWrEn),
  .cfgSel     (cfgSel),
  .cfgWrData  (cfgWrData),
  .reqValid   (reqValid),
  .reqSeg     (reqSeg),
  .busy       (busy),
  .done       (done),
  .segEn      (segEn),
  .devSel     (devSel),
  .wrStrobe   (wrStrobe)
);

// File: tb/segbus_top_tb_top.sv
module segbus_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        strapExm = 1'b1;
  logic        strapQuick = 1'b1;
  logic        cfgWrEn = 1'b0;
  logic        cfgSel = 1'b0;
  logic [15:0] cfgWrData = '0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqSeg = '0;
  logic [15:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqWData = '0;
  logic [15:0] busDataIn = '0;
  logic        busy, done, devSel, wrStrobe;
  logic [15:0] rdData, busAddr, busDataOut;
  logic [3:0]  segEn;

  int checks = 0;
  int errors = 0;
  logic [15:0] curWait;
  logic [15:0] curCfg;

  always #2 clk = ~clk;

  segbus_top dut_i (
    .clk(clk), .rstN(rstN), .strapExm(strapExm), .strapQuick(strapQuick),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .reqValid(reqValid), .reqSeg(reqSeg), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqWData(reqWData), .busDataIn(busDataIn),
    .busy(busy), .done(done), .rdData(rdData), .segEn(segEn),
    .devSel(devSel), .wrStrobe(wrStrobe), .busAddr(busAddr),
    .busDataOut(busDataOut)
  );

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic doReset(input logic exm, input logic quick);
    rstN = 1'b0;
    strapExm = exm;
    strapQuick = quick;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    curWait = (exm && quick) ? 16'h0000 : 16'hFFFF;
    curCfg = 16'h0000;
  endtask

  task automatic cfgWrite(input logic sel, input logic [15:0] data);
    cfgWrEn = 1'b1;
    cfgSel = sel;
    cfgWrData = data;
    @(posedge clk); #1;
    cfgWrEn = 1'b0;
    if (sel) curCfg = data; else curWait = data;
  endtask

  // starts and ends one time unit after a rising edge
  task automatic access(input int seg, input logic [15:0] addr, input logic wr,
                        input logic [15:0] wdata, input bit inject);
    int w;
    int n;
    bit allowed;
    bit earlyOn;
    bit selEarly;
    logic [15:0] pattern;
    logic [15:0] expAddr;
    logic [3:0] oneHot;
    w = int'((curWait >> (seg * 4)) & 16'hF);
    allowed = (seg != 3) || curCfg[11];
    pattern = 16'h5A00 ^ addr ^ 16'(seg << 12);
    expAddr = (seg == 3 && curCfg[14] && curCfg[11]) ? (addr & 16'h7FFF) : addr;
    oneHot = 4'(1 << seg);
    busDataIn = pattern;
    reqValid = 1'b1;
    reqSeg = 2'(seg);
    reqAddr = addr;
    reqWrite = wr;
    reqWData = wdata;
    @(posedge clk); #1;
    reqValid = 1'b0;
    n = 0;
    while (busy === 1'b1 && n < 40) begin
      earlyOn = (n > 0) || !curCfg[seg];
      selEarly = (seg == 1) && ((n > 0) || !curCfg[4]);
      chkEq("R4/R5 early enable", 32'(segEn), earlyOn ? 32'(oneHot) : 32'd0);
      chkEq("R2 done timing", 32'(done), 32'(n == w));
      chkEq("R6 early device select", 32'(devSel), 32'(selEarly ? curCfg[6] : !curCfg[6]));
      chkEq("R7 early write strobe", 32'(wrStrobe), 32'(wr && allowed && earlyOn));
      chkEq("R10 write data", 32'(busDataOut), (wr && allowed && earlyOn) ? 32'(wdata) : 32'd0);
      chkEq("R8 address", 32'(busAddr), 32'(expAddr));
      if (inject && n == 1) begin
        reqValid = 1'b1;
        cfgWrEn = 1'b1;
        cfgSel = 1'b0;
        cfgWrData = 16'h0000;
      end
      #2;
      chkEq("R4/R5 late enable", 32'(segEn), 32'(oneHot));
      chkEq("R6 late device select", 32'(devSel), 32'(seg == 1 ? curCfg[6] : !curCfg[6]));
      chkEq("R7 late write strobe", 32'(wrStrobe), 32'(wr && allowed));
      @(posedge clk); #1;
      reqValid = 1'b0;
      cfgWrEn = 1'b0;
      n++;
    end
    chkEq("R1 access length", 32'(n), 32'(w + 1));
    if (!wr) chkEq("R2 read data", 32'(rdData), 32'(pattern));
    chkEq("R4 idle enables", 32'(segEn), 32'd0);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    // R3: all strap combinations, every segment
    for (int sc = 0; sc < 4; sc++) begin
      doReset(sc[1], sc[0]);
      chkEq("R3 reset busy", 32'(busy), 32'd0);
      chkEq("R3 reset done", 32'(done), 32'd0);
      chkEq("R3 reset enables", 32'(segEn), 32'd0);
      chkEq("R3 reset device select idle", 32'(devSel), 32'd1);
      chkEq("R3 reset write strobe", 32'(wrStrobe), 32'd0);
      for (int s = 0; s < 4; s++) access(s, 16'h1230 + 16'(s), 1'b0, 16'h0, 1'b0);
    end

    doReset(1'b1, 1'b1);
    // R1/R5/R6/R7/R8/R10 sweep
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 16; w++) begin
        for (int m = 0; m < 4; m++) begin
          logic [15:0] wv;
          logic [15:0] cv;
          wv = '0;
          for (int f = 0; f < 4; f++) wv[f*4 +: 4] = (f == s) ? 4'(w) : 4'(15 - w);
          cv = '0;
          if (m[0]) cv = cv | 16'(1 << s) | 16'h0010;
          cv[6] = w[0];
          if (m == 3) begin
            cv[11] = 1'b1;
            cv[14] = w[0];
          end
          cfgWrite(1'b1, cv);
          cfgWrite(1'b0, wv);
          access(s, 16'h8000 | 16'(w << 4) | 16'(s), m[1], 16'hC3C3 ^ 16'(w), 1'b0);
        end
      end
    end

    // R9: register write and request inside a busy access are ignored
    cfgWrite(1'b1, 16'h0000);
    cfgWrite(1'b0, 16'h0500);
    access(2, 16'h0042, 1'b0, 16'h0, 1'b1);
    #2;
    chkEq("R9 no extra access (late half)", 32'(busy), 32'd0);
    @(posedge clk); #1;
    chkEq("R9 no extra access", 32'(busy), 32'd0);
    access(2, 16'h0043, 1'b0, 16'h0, 1'b0);
    access(0, 16'h0044, 1'b0, 16'h0, 1'b0);

    summary();
    $finish;
  end
endmodule